// File: doc/BRIEF.md
# Three-Level Nested Reset Generator

This block produces the system's reset from three nested severities. The deepest level is a whole-device brownout reset. The middle level is a power-on reset. The lightest level is a power-up clear. A deeper level always drives every lighter one, and a lighter level never reaches back into a deeper one. Sources arrive as single-cycle pulses or as level conditions. Some of them are qualified by a configuration input: the external pin has a reset/NMI mode select, the supply supervisor has an enable, and the watchdog has an interval-mode select.

Every level is stretched for a parameterized number of clock cycles after its hold condition goes away. The levels are released deepest first. The block also records a code for the most severe source that fired. That code stays frozen until software acknowledges it with a read strobe. The asynchronous power-good input is the only thing that replaces a frozen code, and it resets the whole block asynchronously. The external pin and the supervisor flag are asynchronous, so they pass through a synchronizer chain before use.

Top module: `rst_casc_gen`

## Requirements
- R1: While `por_n_i` is low, all three reset outputs are high at once, without waiting for a clock edge, and `cause_o` reads 1 (power-up). After release with no other source, `bor_o` falls at the STRETCH-th rising edge, `por_o` at edge 2*STRETCH, and `puc_o` at edge 3*STRETCH.
- R2: The following sources assert `bor_o`, `por_o` and `puc_o` at the next rising edge: `lpm_wake_i`, `sw_bor_i`, `svs_low_i` while `svs_en_i` is 1, and `pin_n_i` low while `pin_nmi_mode_i` is 0. The last two pass through SYNC_STAGES flip-flops first, so with the default of 2, a pin sampled low at edge E drives `bor_o` high after edge E+2.
- R3: A low `pin_n_i` while `pin_nmi_mode_i` is 1 produces no reset. A high `svs_low_i` while `svs_en_i` is 0 produces no reset.
- R4: `sw_por_i` asserts `por_o` and `puc_o` at the next edge and leaves `bor_o` low.
- R5: The following sources assert `puc_o` at the next edge: `wdt_expire_i` only while `wdt_interval_i` is 0, any bit of `pwd_viol_i`, `seg_viol_i`, `periph_fetch_i`, and `ecc_uncorr_i`.
- R6: A source that asserts only `puc_o` never asserts `por_o` or `bor_o`.
- R7: Whenever `bor_o` is high, `por_o` is high. Whenever `por_o` is high, `puc_o` is high.
- R8: Each level stays high for exactly STRETCH edges after the last edge at which its hold was sampled. A level's hold is its own sources or the next deeper level being high, so lighter levels never release before deeper ones.
- R9: When no code is frozen, the most severe active source is recorded on the same edge that asserts its reset. The codes are 2 for the pin, 3 for wake, 4 for the supervisor, 5 for software brownout, 6 for software power-on, and 7 for the watchdog. Password source i records 8+i. After the passwords come segment at 8+NPWD, fetch at 9+NPWD and ECC at 10+NPWD. A lower code wins.
- R10: Once recorded, `cause_o` holds its value until `cause_rd_i` is pulsed. The read unfreezes the code but leaves its value unchanged. Only `por_n_i` low replaces a frozen code, and it writes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Asynchronous power-good, low = power-up reset |
| pin_n_i | input | 1 | Raw external reset/NMI pin, active low, asynchronous |
| pin_nmi_mode_i | input | 1 | 1 = pin is NMI (no reset), 0 = pin resets |
| lpm_wake_i | input | 1 | Wake pulse from deepest low-power mode |
| svs_low_i | input | 1 | Supply supervisor low flag, asynchronous |
| svs_en_i | input | 1 | Supervisor reset enable |
| sw_bor_i | input | 1 | Software brownout request pulse |
| sw_por_i | input | 1 | Software power-on reset request pulse |
| wdt_expire_i | input | 1 | Watchdog expiry pulse |
| wdt_interval_i | input | 1 | 1 = watchdog in interval mode (no reset) |
| pwd_viol_i | input | NPWD | Register password violation strobes |
| seg_viol_i | input | 1 | Memory segment violation strobe |
| periph_fetch_i | input | 1 | Instruction fetch from peripheral space strobe |
| ecc_uncorr_i | input | 1 | Uncorrectable memory bit error strobe |
| cause_rd_i | input | 1 | Software read of the cause code (unfreezes it) |
| bor_o | output | 1 | Brownout-level reset, active high |
| por_o | output | 1 | Power-on-level reset, active high |
| puc_o | output | 1 | Power-up clear, active high |
| cause_o | output | CAUSE_W | Recorded reset cause code |

## Verification
The bench targets four kinds of error, and each shows up at the ports:

- **Qualified sources.** A pin held low in NMI mode, a supervisor flag with its enable off, and a watchdog expiry in interval mode must all leave the outputs at zero. A design that ignored the qualifier would raise a reset.
- **Cascade direction.** It fires a software power-on request and a watchdog expiry alone. A design that cascaded upward would show `bor_o` or `por_o` rising.
- **Stretch length and release order.** It counts the exact number of edges each level stays high. It also checks that `puc_o` is still high at the moment `por_o` drops. An off-by-one counter or an independent per-level timer would be caught.
- **Cause code.** It fires two sources of different severity in the same cycle, and it checks that a frozen code survives new resets until a read. A wrong priority order or a code overwritten before acknowledgement would show in `cause_o`.

// File: rtl/rst_casc_pkg.sv
`timescale 1ns/1ps
package rst_casc_pkg;
   localparam int NUM_LEVELS = 3;
   localparam int LVL_BOR = 0;
   localparam int LVL_POR = 1;
   localparam int LVL_PUC = 2;

   localparam int CODE_PWRUP = 1;
   localparam int CODE_BASE  = 2;

   // source index order is the priority order (lower index wins)
   localparam int SRC_PIN   = 0;
   localparam int SRC_WAKE  = 1;
   localparam int SRC_SVS   = 2;
   localparam int SRC_SWBOR = 3;
   localparam int SRC_SWPOR = 4;
   localparam int SRC_WDT   = 5;
   localparam int SRC_PWD0  = 6;

   function automatic int num_src(input int npwd);
      return SRC_PWD0 + npwd + 3;
   endfunction

   function automatic int cause_width(input int npwd);
      return $clog2(CODE_BASE + num_src(npwd));
   endfunction
endpackage

// File: rtl/rst_casc_sync.sv
`timescale 1ns/1ps
module rst_casc_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rst_casc_stretch.sv
`timescale 1ns/1ps
module rst_casc_stretch #(
   parameter int STRETCH = 16
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic hold_i,
   output logic lvl_o
);
   localparam int CNT_W = $clog2(STRETCH + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cnt_q <= LOAD;
         lvl_o <= 1'b1;
      end else if (hold_i) begin
         cnt_q <= LOAD;
         lvl_o <= 1'b1;
      end else if (cnt_q > ONE) begin
         cnt_q <= cnt_q - ONE;
         lvl_o <= 1'b1;
      end else begin
         cnt_q <= '0;
         lvl_o <= 1'b0;
      end
   end

   // R8: a sampled hold always leaves the level asserted
   a_r8_hold_sets: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      hold_i |=> lvl_o);
   // R8: the level never drops on the edge right after a hold
   a_r8_no_drop_after_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $fell(lvl_o) |-> !$past(hold_i));
endmodule

// File: rtl/rst_casc_cause.sv
`timescale 1ns/1ps
module rst_casc_cause
   import rst_casc_pkg::*;
#(
   parameter int NSRC = 14,
   parameter int CW   = 4
) (
   input  logic            clk_i,
   input  logic            rst_n_i,
   input  logic [NSRC-1:0] src_i,
   input  logic            rd_i,
   output logic [CW-1:0]   cause_o
);
   logic          lock_q;
   logic [CW-1:0] pick;

   always_comb begin
      pick = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (src_i[i]) pick = CW'(CODE_BASE + i);
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cause_o <= CW'(CODE_PWRUP);
         lock_q  <= 1'b1;
      end else if (rd_i) begin
         lock_q  <= 1'b0;
      end else if ((|src_i) && !lock_q) begin
         cause_o <= pick;
         lock_q  <= 1'b1;
      end
   end

   // R10: a frozen code stays put until the read strobe
   a_r10_frozen_code: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (lock_q && !rd_i) |=> $stable(cause_o));
   // R9: the pin is the most severe recordable source
   a_r9_pin_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (src_i[SRC_PIN] && !lock_q && !rd_i) |=> (cause_o == CW'(CODE_BASE)));
endmodule

// File: rtl/rst_casc_gen.sv
`timescale 1ns/1ps
module rst_casc_gen
   import rst_casc_pkg::*;
#(
   parameter int STRETCH     = 16,
   parameter int NPWD        = 5,
   parameter int SYNC_STAGES = 2,
   parameter int CAUSE_W     = 4
) (
   input  logic               clk_i,
   input  logic               por_n_i,
   input  logic               pin_n_i,
   input  logic               pin_nmi_mode_i,
   input  logic               lpm_wake_i,
   input  logic               svs_low_i,
   input  logic               svs_en_i,
   input  logic               sw_bor_i,
   input  logic               sw_por_i,
   input  logic               wdt_expire_i,
   input  logic               wdt_interval_i,
   input  logic [NPWD-1:0]    pwd_viol_i,
   input  logic               seg_viol_i,
   input  logic               periph_fetch_i,
   input  logic               ecc_uncorr_i,
   input  logic               cause_rd_i,
   output logic               bor_o,
   output logic               por_o,
   output logic               puc_o,
   output logic [CAUSE_W-1:0] cause_o
);
   localparam int NSRC = num_src(NPWD);
   localparam int SRC_SEG   = SRC_PWD0 + NPWD;
   localparam int SRC_FETCH = SRC_PWD0 + NPWD + 1;
   localparam int SRC_ECC   = SRC_PWD0 + NPWD + 2;

   // elaboration-time parameter checks
   if (STRETCH < 2) begin : g_bad_stretch
      $error("rst_casc_gen: STRETCH must be at least 2");
   end
   if (NPWD < 1) begin : g_bad_npwd
      $error("rst_casc_gen: NPWD must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rst_casc_gen: SYNC_STAGES must be at least 2");
   end
   if (CAUSE_W < cause_width(NPWD)) begin : g_bad_cw
      $error("rst_casc_gen: CAUSE_W too narrow for the source count");
   end

   // asynchronous inputs: {supervisor flag, pin}
   logic [1:0] async_s;
   rst_casc_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b01)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_n_i (por_n_i),
      .d_i     ({svs_low_i, pin_n_i}),
      .q_o     (async_s)
   );

   logic [NSRC-1:0] src;
   always_comb begin
      src                  = '0;
      src[SRC_PIN]         = ~async_s[0] & ~pin_nmi_mode_i;
      src[SRC_WAKE]        = lpm_wake_i;
      src[SRC_SVS]         = async_s[1] & svs_en_i;
      src[SRC_SWBOR]       = sw_bor_i;
      src[SRC_SWPOR]       = sw_por_i;
      src[SRC_WDT]         = wdt_expire_i & ~wdt_interval_i;
      src[SRC_PWD0 +: NPWD] = pwd_viol_i;
      src[SRC_SEG]         = seg_viol_i;
      src[SRC_FETCH]       = periph_fetch_i;
      src[SRC_ECC]         = ecc_uncorr_i;
   end

   logic [NUM_LEVELS-1:0] trig;
   logic [NUM_LEVELS-1:0] lvl_q;

   assign trig[LVL_BOR] = |src[SRC_SWBOR:SRC_PIN];
   assign trig[LVL_POR] = trig[LVL_BOR] | src[SRC_SWPOR];
   assign trig[LVL_PUC] = |src;

   for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_lvl
      logic hold;
      if (k == 0) begin : g_deepest
         assign hold = trig[k];
      end else begin : g_nested
         assign hold = trig[k] | lvl_q[k-1];
      end
      rst_casc_stretch #(.STRETCH(STRETCH)) u_stretch (
         .clk_i   (clk_i),
         .rst_n_i (por_n_i),
         .hold_i  (hold),
         .lvl_o   (lvl_q[k])
      );
   end

   assign bor_o = lvl_q[LVL_BOR];
   assign por_o = lvl_q[LVL_POR];
   assign puc_o = lvl_q[LVL_PUC];

   rst_casc_cause #(.NSRC(NSRC), .CW(CAUSE_W)) u_cause (
      .clk_i   (clk_i),
      .rst_n_i (por_n_i),
      .src_i   (src),
      .rd_i    (cause_rd_i),
      .cause_o (cause_o)
   );

   // R7: nesting of the three levels
   a_r7_bor_in_por: assert property (@(posedge clk_i) disable iff (!por_n_i)
      bor_o |-> por_o);
   a_r7_por_in_puc: assert property (@(posedge clk_i) disable iff (!por_n_i)
      por_o |-> puc_o);
   // R6: clear-only sources leave the power-on level low
   a_r6_puc_no_por: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!bor_o && !por_o && !trig[LVL_POR]) |=> !por_o);
   // R3: an NMI-mode pin cannot start a brownout
   a_r3_nmi_quiet: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (pin_nmi_mode_i && !bor_o && !(|src[SRC_SWBOR:SRC_WAKE])) |=> !bor_o);
endmodule

// File: tb/rst_casc_gen_tb_top.sv
`timescale 1ns/1ps
module rst_casc_gen_tb_top;
   localparam int N    = 16;
   localparam int NPWD = 5;
   localparam int CW   = 4;
   localparam int NSRC = 14;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic por_n, pin_n, pin_nmi, lpm_wake, svs_low, svs_en, sw_bor, sw_por;
   logic wdt_exp, wdt_int, seg, fetch, ecc, rd;
   logic [NPWD-1:0] pwd;
   logic bor_o, por_o, puc_o;
   logic [CW-1:0] cause_o;

   int checks = 0;
   int errors = 0;

   rst_casc_gen #(.STRETCH(N), .NPWD(NPWD), .SYNC_STAGES(2), .CAUSE_W(CW)) dut_i (
      .clk_i(clk), .por_n_i(por_n), .pin_n_i(pin_n), .pin_nmi_mode_i(pin_nmi),
      .lpm_wake_i(lpm_wake), .svs_low_i(svs_low), .svs_en_i(svs_en),
      .sw_bor_i(sw_bor), .sw_por_i(sw_por), .wdt_expire_i(wdt_exp),
      .wdt_interval_i(wdt_int), .pwd_viol_i(pwd), .seg_viol_i(seg),
      .periph_fetch_i(fetch), .ecc_uncorr_i(ecc), .cause_rd_i(rd),
      .bor_o(bor_o), .por_o(por_o), .puc_o(puc_o), .cause_o(cause_o)
   );

   // reference model state, built from the requirements
   bit m_p1, m_p2, m_s1, m_s2;
   int m_cnt [3];
   bit m_out [3];
   int m_cause;
   bit m_lock;

   function automatic void model_reset();
      m_p1 = 1; m_p2 = 1; m_s1 = 0; m_s2 = 0;
      for (int k = 0; k < 3; k++) begin m_cnt[k] = N; m_out[k] = 1; end
      m_cause = 1; m_lock = 1;
   endfunction

   function automatic void model_step();
      bit [NSRC-1:0] s;
      bit hold [3];
      bit tb, tp, tu;
      int c;
      s = '0;
      s[0] = !m_p2 && !pin_nmi;
      s[1] = lpm_wake;
      s[2] = m_s2 && svs_en;
      s[3] = sw_bor;
      s[4] = sw_por;
      s[5] = wdt_exp && !wdt_int;
      for (int i = 0; i < NPWD; i++) s[6+i] = pwd[i];
      s[6+NPWD] = seg;
      s[7+NPWD] = fetch;
      s[8+NPWD] = ecc;
      tb = |s[3:0];
      tp = tb | s[4];
      tu = |s;
      hold[0] = tb;
      hold[1] = tp | m_out[0];
      hold[2] = tu | m_out[1];
      for (int k = 0; k < 3; k++) begin
         if (hold[k]) begin m_cnt[k] = N; m_out[k] = 1; end
         else if (m_cnt[k] > 1) begin m_cnt[k]--; m_out[k] = 1; end
         else begin m_cnt[k] = 0; m_out[k] = 0; end
      end
      if (rd) m_lock = 0;
      else if ((|s) && !m_lock) begin
         c = 0;
         for (int i = NSRC - 1; i >= 0; i--) if (s[i]) c = 2 + i;
         m_cause = c;
         m_lock = 1;
      end
      m_p2 = m_p1; m_p1 = pin_n;
      m_s2 = m_s1; m_s1 = svs_low;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      @(negedge clk);
      check(bor_o == m_out[0], "R2", "bor_o", int'(bor_o), int'(m_out[0]));
      check(por_o == m_out[1], "R4", "por_o", int'(por_o), int'(m_out[1]));
      check(puc_o == m_out[2], "R5", "puc_o", int'(puc_o), int'(m_out[2]));
      check(int'(cause_o) == m_cause, "R9", "cause_o", int'(cause_o), m_cause);
      check(!(bor_o && !por_o) && !(por_o && !puc_o), "R7", "nesting",
            int'({bor_o, por_o, puc_o}), 0);
   endtask

   task automatic clear_pulses();
      lpm_wake = 0; sw_bor = 0; sw_por = 0; wdt_exp = 0;
      pwd = '0; seg = 0; fetch = 0; ecc = 0; rd = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic read_cause();
      rd = 1; tick(); rd = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd24681));
      por_n = 0; pin_n = 1; pin_nmi = 0; svs_low = 0; svs_en = 1; wdt_int = 0;
      clear_pulses();
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state while power-good is low
      check(bor_o && por_o && puc_o, "R1", "outputs in reset", int'({bor_o, por_o, puc_o}), 7);
      check(cause_o == 1, "R1", "cause in reset", int'(cause_o), 1);
      por_n = 1;
      model_reset();
      // R1/R8: release timing after power-up
      idle(N - 1);
      check(bor_o == 1, "R1", "bor before edge N", int'(bor_o), 1);
      tick();
      check(!bor_o && por_o, "R1", "bor falls at edge N", int'({bor_o, por_o}), 1);
      idle(N);
      check(!por_o && puc_o, "R8", "por falls at edge 2N", int'({por_o, puc_o}), 1);
      idle(N);
      check(!puc_o, "R8", "puc falls at edge 3N", int'(puc_o), 0);

      // R4 and R10: software power-on while code is frozen at power-up
      sw_por = 1; tick(); sw_por = 0;
      check(por_o && !bor_o, "R4", "sw por without bor", int'({bor_o, por_o}), 1);
      check(cause_o == 1, "R10", "frozen code kept", int'(cause_o), 1);
      idle(2 * N + 4);
      read_cause();
      check(cause_o == 1, "R10", "read keeps value", int'(cause_o), 1);
      sw_por = 1; tick(); sw_por = 0;
      check(cause_o == 6, "R9", "sw por code", int'(cause_o), 6);
      idle(2 * N + 4);
      read_cause();

      // R3: pin in NMI mode, supervisor disabled
      pin_nmi = 1; pin_n = 0;
      idle(10);
      check(!bor_o && !por_o && !puc_o, "R3", "nmi pin low", int'({bor_o, por_o, puc_o}), 0);
      pin_n = 1; idle(3); pin_nmi = 0;
      svs_en = 0; svs_low = 1;
      idle(10);
      check(!bor_o && !por_o && !puc_o, "R3", "svs disabled", int'({bor_o, por_o, puc_o}), 0);
      svs_low = 0; idle(3); svs_en = 1;

      // R2: pin in reset mode, synchronizer latency
      pin_n = 0;
      tick(); tick();
      check(!bor_o, "R2", "pin not yet through sync", int'(bor_o), 0);
      tick();
      check(bor_o && por_o && puc_o, "R2", "pin reset asserted", int'({bor_o, por_o, puc_o}), 7);
      check(cause_o == 2, "R9", "pin code", int'(cause_o), 2);
      pin_n = 1;
      idle(3 * N + 6);
      check(!puc_o, "R8", "all released after pin", int'(puc_o), 0);
      read_cause();

      // R5/R6: watchdog modes
      wdt_int = 1; wdt_exp = 1; tick(); wdt_exp = 0;
      idle(3);
      check(!puc_o, "R5", "interval-mode expiry ignored", int'(puc_o), 0);
      wdt_int = 0; wdt_exp = 1; tick(); wdt_exp = 0;
      check(puc_o && !por_o && !bor_o, "R6", "wdt clear only", int'({bor_o, por_o, puc_o}), 1);
      check(cause_o == 7, "R9", "wdt code", int'(cause_o), 7);
      idle(N + 4);
      read_cause();

      // R9: simultaneous sources of different severity
      sw_bor = 1; ecc = 1; tick(); sw_bor = 0; ecc = 0;
      check(cause_o == 5 && bor_o, "R9", "sw bor beats ecc", int'(cause_o), 5);
      idle(3 * N + 6);
      read_cause();

      // R5: password violation source 2
      pwd = 5'b00100; tick(); pwd = '0;
      check(puc_o && !por_o, "R5", "password clear only", int'({por_o, puc_o}), 1);
      check(cause_o == 10, "R9", "password 2 code", int'(cause_o), 10);
      idle(N + 4);
      read_cause();

      // R8: stretch length after a held request, ordered release
      begin
         int cnt;
         sw_por = 1; idle(5); sw_por = 0;
         cnt = 0;
         for (int i = 1; i <= N + 2; i++) begin
            tick();
            cnt = i;
            if (!por_o) break;
         end
         check(cnt == N, "R8", "por stretch edges", cnt, N);
         check(puc_o == 1, "R8", "puc outlives por", int'(puc_o), 1);
      end
      idle(N + 4);
      read_cause();

      // constrained random phase
      for (int it = 0; it < 2500; it++) begin
         if (it % 64 == 0) begin
            pin_nmi = 1'($urandom % 2);
            svs_en  = 1'($urandom % 2);
            wdt_int = 1'($urandom % 2);
         end
         pin_n    = ($urandom % 48) != 0;
         svs_low  = ($urandom % 48) == 0;
         lpm_wake = ($urandom % 60) == 0;
         sw_bor   = ($urandom % 70) == 0;
         sw_por   = ($urandom % 50) == 0;
         wdt_exp  = ($urandom % 30) == 0;
         pwd      = (($urandom % 20) == 0) ? (NPWD'(1) << ($urandom % NPWD)) : '0;
         seg      = ($urandom % 60) == 0;
         fetch    = ($urandom % 60) == 0;
         ecc      = ($urandom % 80) == 0;
         rd       = ($urandom % 10) == 0;
         tick();
      end
      clear_pulses();
      pin_n = 1; svs_low = 0; pin_nmi = 0; svs_en = 1; wdt_int = 0;
      idle(3 * N + 6);

      // R1: mid-cycle power loss asserts without a clock edge
      #1 por_n = 0;
      #1;
      check(bor_o && por_o && puc_o, "R1", "async assert", int'({bor_o, por_o, puc_o}), 7);
      check(cause_o == 1, "R10", "power-up replaces code", int'(cause_o), 1);
      @(negedge clk);
      por_n = 1;
      model_reset();
      idle(3 * N + 4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule